// File: doc/BRIEF.md
# Decimating Polyphase Branch Filter

This block is one arm of a four-way decimating polyphase filterbank that sits in front of a four-point DFT. It watches the full-rate complex sample stream and counts valid samples round-robin. It keeps only the samples whose slot matches its own branch index. Each kept sample goes into a circular delay line held in synchronous RAM, with one RAM for the real part and one for the imaginary part.

Every kept sample starts one filtering pass. A single multiply-accumulate unit per lane walks all taps, one tap per clock. The unit fetches coefficients from an external synchronous ROM through an address port. The real and imaginary lanes share the same real coefficient.

The finished sum is rounded, saturated to the sample width and presented on a valid/ready output. If a branch sample arrives while a pass is still running, or while a result is still waiting to be taken, the block drops that sample and pulses an overrun flag.

Top module: `pfb_branch`

## Requirements
- R1: While rst_ni is low, and after it is released until the first result, res_valid_o and overrun_o are 0.
- R2: Valid input samples are numbered from 0 after reset. Sample j belongs to this branch only when j mod NUM_BR equals BRANCH. Other samples never enter the delay line and never produce a result, whatever their value.
- R3: Each accepted branch sample yields exactly one result. If the sample is taken at clock edge E, res_valid_o is high after edge E+TAPS+2.
- R4: With newest sample x[0] and coefficients c[k] in signed Q1.15, each lane outputs sat16((sum over k of c[k]*x[k] + 2^14) >>> 15). Here x[k] is the k-th older accepted sample of that lane. Both lanes use the same c[k].
- R5: The delay line is circular over TAPS entries. Only the newest TAPS accepted samples contribute. Taps older than the first accepted sample since reset count as zero.
- R6: Results above 32767 are clamped to 32767. Results below -32768 are clamped to -32768.
- R7: A result holds res_valid_o and its value until res_ready_i is high at a clock edge. While a result is unconsumed, the block counts as busy.
- R8: A branch sample that arrives while busy sets overrun_o high for the one cycle after its edge. The sample is discarded: later results are computed as if it never arrived, and the round-robin count still advances.
- R9: In the TAPS cycles that follow an accepting edge, coef_addr_o takes the values 0, 1, ..., TAPS-1 in consecutive cycles. coef_i must return the addressed coefficient one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Full-rate input sample valid |
| smp_re_i | input | DATA_W | Input sample, real part |
| smp_im_i | input | DATA_W | Input sample, imaginary part |
| coef_addr_o | output | clog2(TAPS) | Coefficient ROM address |
| coef_i | input | COEF_W | Coefficient, one cycle after its address |
| res_valid_o | output | 1 | Filtered result valid |
| res_ready_i | input | 1 | Result taken by the consumer |
| res_re_o | output | DATA_W | Filtered result, real part |
| res_im_o | output | DATA_W | Filtered result, imaginary part |
| overrun_o | output | 1 | One-cycle pulse: branch sample dropped |

## Verification
A write pointer that steps wrongly stays hidden until the delay line wraps. From the first result after TAPS branch samples, the outputs mix the wrong history, so long random runs are needed to expose it. A tap counter or pipeline stage that is off by one shows at once: the first result appears in the wrong cycle, or a coefficient is paired with the wrong sample.

Rounding or clamp mistakes show as a one-LSB or wrap-around error on the very first nonzero result. A busy flag that clears too early lets a second branch sample corrupt a running sum without any overrun pulse. That shows on the next result.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // tag travelling with each issued tap
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
    logic zero;
  } tap_tag_t;

endpackage

// File: rtl/pfb_dline_ram.sv
module pfb_dline_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/pfb_seq.sv
module pfb_seq
  import pfb_pkg::*;
#(
  parameter int TAPS   = 256,
  parameter int NUM_BR = 4,
  parameter int BRANCH = 0,
  parameter int AW     = $clog2(TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic          out_pending_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW-1:0] coef_addr_o,
  output logic          mac_en_o,
  output logic          mac_first_o,
  output logic          mac_zero_o,
  output logic          fin_o,
  output logic          overrun_o
);

  localparam int PW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1;
  localparam int FW = $clog2(TAPS + 1);
  localparam logic [AW-1:0] LAST    = AW'(TAPS - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(NUM_BR - 1);
  localparam logic [PW-1:0] PH_SEL  = PW'(BRANCH);
  localparam logic [FW-1:0] FULL    = FW'(TAPS);

  logic [PW-1:0] ph_q;
  logic [AW-1:0] wp_q, rd_q, k_q;
  logic [FW-1:0] fill_q;
  logic          run_q, fin_q, ovr_q;
  tap_tag_t      iss, tag_q;
  logic          hit, busy, start;

  assign hit   = smp_valid_i && (ph_q == PH_SEL);
  assign busy  = run_q | tag_q.vld | fin_q | out_pending_i;
  assign start = hit & ~busy;

  always_comb begin
    iss.vld   = run_q;
    iss.first = run_q && (k_q == '0);
    iss.last  = run_q && (k_q == LAST);
    // taps past the oldest sample since reset read as zero
    iss.zero  = run_q && (FW'(k_q) >= fill_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      wp_q   <= '0;
      rd_q   <= '0;
      k_q    <= '0;
      fill_q <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      ovr_q  <= 1'b0;
      tag_q  <= '0;
    end else begin
      ovr_q <= hit & busy;
      fin_q <= tag_q.vld & tag_q.last;
      tag_q <= iss;
      if (smp_valid_i) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (start) begin
        wp_q  <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
        if (fill_q != FULL) fill_q <= fill_q + 1'b1;
        run_q <= 1'b1;
        k_q   <= '0;
        rd_q  <= wp_q;
      end else if (run_q) begin
        rd_q <= (rd_q == '0) ? LAST : rd_q - 1'b1;
        if (k_q == LAST) begin
          k_q   <= '0;
          run_q <= 1'b0;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end

  assign we_o        = start;
  assign waddr_o     = wp_q;
  assign raddr_o     = rd_q;
  assign coef_addr_o = k_q;
  assign mac_en_o    = tag_q.vld;
  assign mac_first_o = tag_q.first;
  assign mac_zero_o  = tag_q.zero;
  assign fin_o       = fin_q;
  assign overrun_o   = ovr_q;

  // R9
  coef_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q <= LAST);

  // R9
  coef_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !iss.last |=> run_q && (k_q == $past(k_q) + 1'b1));

  // R5
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_q <= LAST) && (rd_q <= LAST));

  // R5
  newest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss.first |-> rd_q == $past(wp_q));

  // R3
  fin_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> $past(tag_q.last));

endmodule

// File: rtl/pfb_mac_lane.sv
module pfb_mac_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    first_i,
  input  logic                    zero_i,
  input  logic [DATA_W-1:0]       x_i,
  input  logic [COEF_W-1:0]       c_i,
  output logic signed [ACC_W-1:0] acc_o
);

  localparam int PW = DATA_W + COEF_W;

  logic signed [PW-1:0]    xe, ce, prod;
  logic signed [ACC_W-1:0] prod_x, acc_q;

  always_comb begin
    xe     = PW'($signed(x_i));
    ce     = PW'($signed(c_i));
    prod   = zero_i ? '0 : xe * ce;
    prod_x = ACC_W'(prod);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= first_i ? prod_x : acc_q + prod_x;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/pfb_rnd_sat.sv
module pfb_rnd_sat #(
  parameter int IN_W  = 40,
  parameter int FRAC  = 15,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  acc_i,
  output logic signed [OUT_W-1:0] y_o
);

  localparam int TW = IN_W + 1;
  localparam logic signed [TW-1:0] HALF = TW'(2 ** (FRAC - 1));
  localparam logic signed [TW-1:0] MAXV = TW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [TW-1:0] MINV = ~MAXV;

  logic signed [TW-1:0] sum, sh;

  always_comb begin
    sum = TW'(acc_i) + HALF;
    sh  = sum >>> FRAC;
    if (sh > MAXV)      y_o = MAXV[OUT_W-1:0];
    else if (sh < MINV) y_o = MINV[OUT_W-1:0];
    else                y_o = sh[OUT_W-1:0];
  end

endmodule

// File: rtl/pfb_branch.sv
module pfb_branch
  import pfb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int TAPS   = 256,
  parameter int NUM_BR = 4,
  parameter int BRANCH = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      smp_valid_i,
  input  logic [DATA_W-1:0]         smp_re_i,
  input  logic [DATA_W-1:0]         smp_im_i,
  output logic [$clog2(TAPS)-1:0]   coef_addr_o,
  input  logic [COEF_W-1:0]         coef_i,
  output logic                      res_valid_o,
  input  logic                      res_ready_i,
  output logic [DATA_W-1:0]         res_re_o,
  output logic [DATA_W-1:0]         res_im_o,
  output logic                      overrun_o
);

  localparam int AW    = $clog2(TAPS);
  localparam int ACC_W = DATA_W + COEF_W + AW;
  localparam int FRAC  = COEF_W - 1;

  logic          we, mac_en, mac_first, mac_zero, fin, pending;
  logic [AW-1:0] waddr, raddr;

  logic [DATA_W-1:0]       lane_in  [2];
  logic [DATA_W-1:0]       lane_rd  [2];
  logic [DATA_W-1:0]       lane_y   [2];
  logic [DATA_W-1:0]       res_q    [2];
  logic signed [ACC_W-1:0] lane_acc [2];
  logic                    vld_q;

  assign lane_in[0] = smp_re_i;
  assign lane_in[1] = smp_im_i;
  assign pending    = vld_q & ~res_ready_i;

  pfb_seq #(
    .TAPS(TAPS), .NUM_BR(NUM_BR), .BRANCH(BRANCH), .AW(AW)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .smp_valid_i  (smp_valid_i),
    .out_pending_i(pending),
    .we_o         (we),
    .waddr_o      (waddr),
    .raddr_o      (raddr),
    .coef_addr_o  (coef_addr_o),
    .mac_en_o     (mac_en),
    .mac_first_o  (mac_first),
    .mac_zero_o   (mac_zero),
    .fin_o        (fin),
    .overrun_o    (overrun_o)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    pfb_dline_ram #(.W(DATA_W), .DEPTH(TAPS), .AW(AW)) u_ram (
      .clk_i  (clk_i),
      .we_i   (we),
      .waddr_i(waddr),
      .wdata_i(lane_in[l]),
      .raddr_i(raddr),
      .rdata_o(lane_rd[l])
    );

    pfb_mac_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (mac_en),
      .first_i(mac_first),
      .zero_i (mac_zero),
      .x_i    (lane_rd[l]),
      .c_i    (coef_i),
      .acc_o  (lane_acc[l])
    );

    pfb_rnd_sat #(.IN_W(ACC_W), .FRAC(FRAC), .OUT_W(DATA_W)) u_rnd (
      .acc_i(lane_acc[l]),
      .y_o  (lane_y[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '{default: '0};
    end else if (fin) begin
      vld_q    <= 1'b1;
      res_q[0] <= lane_y[0];
      res_q[1] <= lane_y[1];
    end else if (res_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign res_valid_o = vld_q;
  assign res_re_o    = res_q[0];
  assign res_im_o    = res_q[1];

  // R7
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_re_o) && $stable(res_im_o));

  // R3
  res_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(fin));

  // R8
  ovr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(smp_valid_i));

  // R8
  ovr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o);

endmodule

// File: tb/pfb_branch_tb.sv
module pfb_branch_tb;

  localparam int T  = 16;
  localparam int BR = 1;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_re = '0, smp_im = '0;
  logic [3:0]  coef_addr;
  logic [15:0] coef_q = '0;
  logic        res_valid, res_ready = 1'b1, overrun;
  logic [15:0] res_re, res_im;

  always #4ns clk = ~clk;

  pfb_branch #(
    .DATA_W(16), .COEF_W(16), .TAPS(T), .NUM_BR(NB), .BRANCH(BR)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .smp_valid_i(smp_valid),
    .smp_re_i   (smp_re),
    .smp_im_i   (smp_im),
    .coef_addr_o(coef_addr),
    .coef_i     (coef_q),
    .res_valid_o(res_valid),
    .res_ready_i(res_ready),
    .res_re_o   (res_re),
    .res_im_o   (res_im),
    .overrun_o  (overrun)
  );

  // synchronous coefficient ROM, one cycle latency
  logic [15:0] rom [T];
  always @(posedge clk) coef_q <= rom[coef_addr];

  int n_chk = 0, n_bad = 0, cyc = 0, n_out = 0, n_acc = 0;
  int ph, br_cyc, hlen;
  bit last_ovr;
  int hre [256];
  int him [256];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rst_n && res_valid && res_ready) n_out <= n_out + 1;

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int model(bit im);
    longint s = 0;
    for (int k = 0; k < T; k++) begin
      int idx = hlen - 1 - k;
      if (idx >= 0) s += longint'($signed(rom[k])) * longint'(im ? him[idx] : hre[idx]);
    end
    s = (s + 16384) >>> 15;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic push(int re, int im);
    hre[hlen] = re;
    him[hlen] = im;
    hlen++;
    n_acc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; res_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hlen = 0; ph = 0;
    @(negedge clk);
  endtask

  // starts and ends at a negedge
  task automatic drive_one(int re, int im);
    smp_valid = 1'b1;
    smp_re = 16'(re);
    smp_im = 16'(im);
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    if (ph == BR) begin
      br_cyc   = cyc;
      last_ovr = overrun;
    end
    ph = (ph + 1) % NB;
  endtask

  task automatic wait_out(int er, int ei, bit chk_lat, string req);
    int guard = 0;
    while (!res_valid && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    chk(res_valid, {req, " result present"}, res_valid, 1);
    if (chk_lat) chk(cyc - br_cyc == T + 2, "R3 latency", cyc - br_cyc, T + 2);
    chk(int'($signed(res_re)) == er, {req, " real"}, int'($signed(res_re)), er);
    chk(int'($signed(res_im)) == ei, {req, " imag"}, int'($signed(res_im)), ei);
  endtask

  // one round of NB inputs, branch slot carries re/im
  task automatic send_round(int re, int im, bit extreme);
    for (int s = 0; s < NB; s++) begin
      if (ph == BR) drive_one(re, im);
      else if (extreme) drive_one((s % 2) ? 32767 : -32768, (s % 2) ? -32768 : 32767);
      else drive_one(int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);
    end
  endtask

  task automatic frame(int re, int im, bit extreme, string req);
    send_round(re, im, extreme);
    push(re, im);
    wait_out(model(0), model(1), 1'b1, req);
  endtask

  task automatic rand_rom(int span);
    for (int k = 0; k < T; k++) rom[k] = 16'(int'($urandom_range(2 * span)) - span);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!res_valid, "R1 valid in reset", res_valid, 0);
    chk(!overrun, "R1 overrun in reset", overrun, 0);
    do_reset();
    repeat (3) @(negedge clk);
    chk(!res_valid && !overrun, "R1 idle after reset", {res_valid, overrun}, 0);
  endtask

  task automatic t_impulse();
    do_reset();
    for (int k = 0; k < T; k++) rom[k] = 16'(k * 2048 - 15000);
    frame(16384, -8192, 1'b0, "R4 impulse");
    for (int j = 0; j < T + 2; j++) frame(0, 0, 1'b0, "R4 impulse tail");
  endtask

  task automatic t_offbranch();
    do_reset();
    rand_rom(8000);
    for (int j = 0; j < 6; j++) frame(0, 0, 1'b1, "R2 foreign samples ignored");
    frame(1000, -3000, 1'b1, "R2 branch sample among extremes");
  endtask

  task automatic t_stream();
    do_reset();
    rand_rom(8000);
    for (int j = 0; j < 3 * T; j++)
      frame(int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
            1'b0, "R5 circular history");
  endtask

  task automatic t_sat();
    do_reset();
    for (int k = 0; k < T; k++) rom[k] = 16'd32767;
    for (int j = 0; j < 3; j++) frame(32767, -32768, 1'b0, "R6 clamp");
  endtask

  task automatic t_hold();
    int hr, hi;
    do_reset();
    rand_rom(8000);
    res_ready = 1'b0;
    frame(12000, -7000, 1'b0, "R7 first result");
    hr = int'(res_re);
    hi = int'(res_im);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(res_valid && int'(res_re) == hr && int'(res_im) == hi, "R7 held while not ready",
          int'(res_re), hr);
    end
    send_round(20000, 20000, 1'b0);
    chk(last_ovr, "R7 pending result makes block busy", last_ovr, 1);
    chk(res_valid && int'(res_re) == hr, "R7 value kept", int'(res_re), hr);
    res_ready = 1'b1;
    @(negedge clk);
    chk(!res_valid, "R7 released after ready", res_valid, 0);
    frame(-5000, 9000, 1'b0, "R8 dropped sample absent");
  endtask

  task automatic t_overrun();
    do_reset();
    rand_rom(8000);
    send_round(7000, -4000, 1'b0);
    push(7000, -4000);
    send_round(30000, 30000, 1'b0);
    chk(last_ovr, "R8 overrun pulse", last_ovr, 1);
    chk(!overrun, "R8 pulse is one cycle", overrun, 0);
    wait_out(model(0), model(1), 1'b0, "R8 running sum untouched");
    frame(-9000, 11000, 1'b0, "R8 history excludes dropped");
    chk(!last_ovr, "R8 no overrun when idle", last_ovr, 0);
  endtask

  task automatic t_addr();
    do_reset();
    rand_rom(8000);
    drive_one(123, 456);
    drive_one(2500, -2500);
    push(2500, -2500);
    for (int k = 0; k < T; k++) begin
      chk(int'(coef_addr) == k, "R9 coefficient address walk", int'(coef_addr), k);
      @(negedge clk);
    end
    wait_out(model(0), model(1), 1'b1, "R9 result after walk");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < T; k++) rom[k] = '0;
    t_reset();
    t_impulse();
    t_offbranch();
    t_stream();
    t_sat();
    t_hold();
    t_overrun();
    t_addr();
    repeat (4) @(negedge clk);
    chk(n_out == n_acc, "R3 one result per accepted sample", n_out, n_acc);
    summary();
    $finish;
  end

endmodule